// File: doc/BRIEF.md
# I2C SCL Bit-Rate Generator

This block produces the SCL clock of an I2C master from the system clock. A 3-bit select divides the system clock by a power of two to form a reference tick. Two 5-bit counts set how many ticks the low phase and the high phase last. Both bus lines pass through a tick-clocked synchroniser and a one-tick noise filter. Their latency, 4 ticks when the prescaler is bypassed and 3 ticks otherwise, is part of every phase. The SCL output is open-drain style: the block only ever pulls the line low or lets it go.

A phase starts counting only once the filtered SCL shows the level the block is driving. A slave that holds SCL low therefore stretches the clock, and the same rule governs the low phase. The block also gives the byte engine three strobes. The first is a one-cycle pulse each time SCL is pulled low, which is when SDA may change. The others mark a start condition or a stop condition on the filtered SDA, but only once SCL has been high for at least one high-phase period. When the block is disabled, SCL is released and the condition detectors keep watching the bus.

Top module: `scl_rate_gen`

## Requirements
- R1: A reference tick occurs once every 2^S system clocks, where S is `presc_sel_i`; a select of 7 acts as 6. All phase counting and line filtering advance only on ticks.
- R2: With no other device holding SCL, each pull-low phase (`scl_low_o` = 1) lasts L + K ticks. L is `low_cnt_i`, and K is 4 when the select is 0 and 3 otherwise.
- R3: With no other device holding SCL, each released phase (`scl_low_o` = 0, enabled) lasts H + K ticks. H is `high_cnt_i` and K is as in R2.
- R4: A count of 0 in `low_cnt_i` or `high_cnt_i` acts as 1.
- R5: The high-phase count begins only once the filtered SCL is high. When another device keeps SCL low for T extra ticks after release, the released phase lasts T + H + K ticks.
- R6: `start_o` pulses for one clock when the filtered SDA falls while the filtered SCL is high and has been high for at least H ticks. It does not pulse when SCL is low, or when SCL rises on the same tick that SDA falls.
- R7: `stop_o` pulses for one clock when the filtered SDA rises under the same SCL conditions as R6.
- R8: After reset, and for as long as `en_i` is low, `scl_low_o` is 0 and `bit_tick_o` stays 0. When the block is enabled with SCL settled high, it first holds SCL released for H ticks, then pulls it low.
- R9: `bit_tick_o` is high for exactly one clock, the clock in which `scl_low_o` becomes 1, once for every pull-low.
- R10: A level on SCL or SDA that lasts for only one tick is not passed by the filter, so a one-tick SDA glitch while SCL is high yields neither `start_o` nor `stop_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run the SCL generator; low releases SCL |
| presc_sel_i | input | 3 | Prescaler select S, tick every 2^S clocks |
| low_cnt_i | input | 5 | Low-phase count L |
| high_cnt_i | input | 5 | High-phase count H, also the start/stop setup requirement |
| scl_i | input | 1 | Sampled SCL bus level |
| sda_i | input | 1 | Sampled SDA bus level |
| scl_low_o | output | 1 | 1 pulls SCL low, 0 releases it |
| bit_tick_o | output | 1 | One-clock pulse when SCL is pulled low |
| start_o | output | 1 | One-clock start condition strobe |
| stop_o | output | 1 | One-clock stop condition strobe |

## Verification
A wrong phase count or a wrong synchroniser tap shows within one SCL period as a low or high time that misses (L+K)·2^S or (H+K)·2^S clocks. The bench measures every edge of `scl_low_o` against those values. A stuck or mis-sized prescaler multiplies every measured phase, and a broken stretch rule shortens the first stretched high phase by the hold time. A filter that lets a single tick through, or a setup counter that is never checked, shows at once as a stray `start_o` or `stop_o` pulse in the glitch, low-SCL or simultaneous-edge windows.

// File: rtl/scl_gen_pkg.sv
`timescale 1ns/1ps
package scl_gen_pkg;
  localparam int unsigned SEL_W    = 3;
  localparam int unsigned CNT_W    = 5;
  localparam int unsigned SEL_MAX  = 6;
  localparam int unsigned SYNC_MAX = 3;

  function automatic logic [CNT_W-1:0] floor_one(input logic [CNT_W-1:0] v);
    return (v == '0) ? CNT_W'(1) : v;
  endfunction
endpackage

// File: rtl/scl_prescaler.sv
`timescale 1ns/1ps
module scl_prescaler
  import scl_gen_pkg::*;
#(
  parameter int unsigned SW = SEL_W,
  parameter int unsigned SM = SEL_MAX
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [SW-1:0] sel_i,
  output logic          tick_o,
  output logic          deep_o
);
  localparam int unsigned DW = (SM < 1) ? 1 : SM;

  logic [DW-1:0] div_q;
  logic [DW-1:0] mask;
  logic [SW-1:0] sel_c;

  assign sel_c  = (sel_i > SW'(SM)) ? SW'(SM) : sel_i;
  assign mask   = DW'((1 << sel_c) - 1);
  assign tick_o = ((div_q & mask) == mask);
  // bypassed prescaler takes the deeper synchroniser tap
  assign deep_o = (sel_c == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + DW'(1);
  end

  // R1
  tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && sel_c != '0) |=> (!tick_o || sel_c != $past(sel_c)));
endmodule

// File: rtl/scl_line_filter.sv
`timescale 1ns/1ps
module scl_line_filter
  import scl_gen_pkg::*;
#(
  parameter int unsigned DEPTH = SYNC_MAX
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic deep_i,
  input  logic lvl_i,
  output logic lvl_o
);
  logic [DEPTH-1:0] sync_q;
  logic             lvl_q;
  logic             far_s, near_s;

  // deep: 3-stage sync, else 2-stage; filter needs two equal samples
  assign far_s  = deep_i ? sync_q[DEPTH-1] : sync_q[DEPTH-2];
  assign near_s = deep_i ? sync_q[DEPTH-2] : sync_q[DEPTH-3];
  assign lvl_o  = lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      lvl_q  <= 1'b1;
    end else if (tick_i) begin
      sync_q <= {sync_q[DEPTH-2:0], lvl_i};
      if (far_s == near_s) lvl_q <= far_s;
    end
  end

  // R1
  filt_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(lvl_q) |-> $past(tick_i));
endmodule

// File: rtl/scl_phase_fsm.sv
`timescale 1ns/1ps
module scl_phase_fsm
  import scl_gen_pkg::*;
#(
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic          scl_f_i,
  input  logic [CW-1:0] low_t_i,
  input  logic [CW-1:0] high_t_i,
  output logic          scl_low_o,
  output logic          bit_tick_o
);
  logic          low_q, tick_q;
  logic [CW-1:0] cnt_q, tgt;

  assign tgt        = low_q ? low_t_i : high_t_i;
  assign scl_low_o  = low_q;
  assign bit_tick_o = tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q  <= 1'b0;
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= 1'b0;
      if (!en_i) begin
        low_q <= 1'b0;
        cnt_q <= '0;
      end else if (tick_i) begin
        // count only while the bus shows the driven level
        if (scl_f_i == ~low_q) begin
          if (cnt_q >= tgt - CW'(1)) begin
            low_q  <= ~low_q;
            cnt_q  <= '0;
            tick_q <= ~low_q;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end else begin
          cnt_q <= '0;
        end
      end
    end
  end

  // R9
  tick_at_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |-> (scl_low_o && !$past(scl_low_o)));
  // R9
  fall_has_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_low_o) |-> bit_tick_o);
  // R8
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !scl_low_o);
  // R2
  edge_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($changed(scl_low_o) && $past(en_i)) |-> $past(tick_i));
endmodule

// File: rtl/scl_cond_detect.sv
`timescale 1ns/1ps
module scl_cond_detect
  import scl_gen_pkg::*;
#(
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          scl_f_i,
  input  logic          sda_f_i,
  input  logic [CW-1:0] high_t_i,
  output logic          start_o,
  output logic          stop_o
);
  logic          sda_prev_q, start_q, stop_q;
  logic [CW-1:0] hi_q;

  assign start_o = start_q;
  assign stop_o  = stop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sda_prev_q <= 1'b1;
      hi_q       <= '0;
      start_q    <= 1'b0;
      stop_q     <= 1'b0;
    end else begin
      start_q <= 1'b0;
      stop_q  <= 1'b0;
      if (tick_i) begin
        sda_prev_q <= sda_f_i;
        // saturating count of ticks with SCL high
        hi_q <= scl_f_i ? ((hi_q == '1) ? hi_q : hi_q + CW'(1)) : '0;
        if (scl_f_i && hi_q >= high_t_i) begin
          start_q <= sda_prev_q & ~sda_f_i;
          stop_q  <= ~sda_prev_q & sda_f_i;
        end
      end
    end
  end

  // R6
  start_when_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> ($past(scl_f_i) && !$past(sda_f_i)));
  // R7
  stop_when_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> ($past(scl_f_i) && $past(sda_f_i)));
endmodule

// File: rtl/scl_rate_gen.sv
`timescale 1ns/1ps
module scl_rate_gen
  import scl_gen_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] presc_sel_i,
  input  logic [CNT_W-1:0] low_cnt_i,
  input  logic [CNT_W-1:0] high_cnt_i,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_low_o,
  output logic             bit_tick_o,
  output logic             start_o,
  output logic             stop_o
);
  localparam int unsigned NLINE = 2;

  logic             ref_tick, deep_sync;
  logic [NLINE-1:0] raw_lines, filt_lines;
  logic [CNT_W-1:0] low_t, high_t;

  assign low_t     = floor_one(low_cnt_i);
  assign high_t    = floor_one(high_cnt_i);
  assign raw_lines = {sda_i, scl_i};

  scl_prescaler #(.SW(SEL_W), .SM(SEL_MAX)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (presc_sel_i),
    .tick_o (ref_tick),
    .deep_o (deep_sync)
  );

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    scl_line_filter #(.DEPTH(SYNC_MAX)) u_flt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (ref_tick),
      .deep_i (deep_sync),
      .lvl_i  (raw_lines[g]),
      .lvl_o  (filt_lines[g])
    );
  end

  scl_phase_fsm #(.CW(CNT_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .tick_i     (ref_tick),
    .scl_f_i    (filt_lines[0]),
    .low_t_i    (low_t),
    .high_t_i   (high_t),
    .scl_low_o  (scl_low_o),
    .bit_tick_o (bit_tick_o)
  );

  scl_cond_detect #(.CW(CNT_W)) u_cond (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (ref_tick),
    .scl_f_i  (filt_lines[0]),
    .sda_f_i  (filt_lines[1]),
    .high_t_i (high_t),
    .start_o  (start_o),
    .stop_o   (stop_o)
  );
endmodule

// File: tb/scl_rate_gen_bench.sv
`timescale 1ns/1ps
module scl_rate_gen_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en = 1'b0;
  logic [2:0] sel = 3'd0;
  logic [4:0] lo = 5'd5, hi = 5'd3;
  logic       slave_hold = 1'b0, sda_drv = 1'b1;
  logic       scl_line;
  logic       scl_low, bit_tick, start, stop;

  always #4 clk = ~clk;

  // open-drain bus: low if the block or a slave pulls it
  assign scl_line = ~scl_low & ~slave_hold;

  scl_rate_gen u_scl_rate_gen (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .en_i        (en),
    .presc_sel_i (sel),
    .low_cnt_i   (lo),
    .high_cnt_i  (hi),
    .scl_i       (scl_line),
    .sda_i       (sda_drv),
    .scl_low_o   (scl_low),
    .bit_tick_o  (bit_tick),
    .start_o     (start),
    .stop_o      (stop)
  );

  typedef struct { int dur; string req; } exp_t;
  exp_t q[$];
  exp_t got;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int last_edge = 0, rises = 0, ticks = 0, starts = 0, stops = 0;
  logic last_lvl = 1'b0;
  int stretch_len = 0, s_cnt = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: measure each SCL phase and compare with the scoreboard
  always @(negedge clk) begin
    if (rst_ni) begin
      if (bit_tick) begin
        ticks++;
        chk(scl_low && !last_lvl, "R9 tick not at pull-low", int'(scl_low), 1);
      end
      if (start) starts++;
      if (stop) stops++;
      if (scl_low != last_lvl) begin
        if (scl_low) rises++;
        if (q.size() > 0) begin
          got = q.pop_front();
          chk((cyc - last_edge) == got.dur, got.req, cyc - last_edge, got.dur);
        end
        last_edge = cyc;
        last_lvl  = scl_low;
      end
    end
  end

  // slave that stretches every released phase
  always @(negedge clk) begin
    if (stretch_len > 0) begin
      if (scl_low) begin
        slave_hold = 1'b1;
        s_cnt = 0;
      end else if (slave_hold) begin
        s_cnt++;
        if (s_cnt == stretch_len) slave_hold = 1'b0;
      end
    end
  end

  // driver: run the generator and push expected phase lengths
  task automatic run_phases(input int s, input int l, input int h, input int nph,
                            input int str, input string rl, input string rh);
    int p, ov, lt, ht;
    exp_t e;
    en = 1'b0;
    sel = 3'(s); lo = 5'(l); hi = 5'(h);
    stretch_len = str;
    repeat (8) @(negedge clk);
    q.delete();
    en = 1'b1;
    @(posedge scl_low);
    @(negedge clk);
    #1;
    p  = 1 << ((s > 6) ? 6 : s);
    ov = (s == 0) ? 4 : 3;
    lt = (l == 0) ? 1 : l;
    ht = (h == 0) ? 1 : h;
    for (int i = 0; i < nph; i++) begin
      e.dur = (i % 2 == 0) ? (lt + ov) * p : (ht + ov) * p + ((str > 0) ? str - 1 : 0);
      e.req = (i % 2 == 0) ? rl : rh;
      q.push_back(e);
    end
    while (q.size() > 0) @(negedge clk);
    en = 1'b0;
    stretch_len = 0;
    slave_hold = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cond_window(input int want_start, input int want_stop, input string req);
    int s0, p0;
    s0 = starts; p0 = stops;
    repeat (30) @(negedge clk);
    chk(starts - s0 == want_start, {req, " start count"}, starts - s0, want_start);
    chk(stops - p0 == want_stop, {req, " stop count"}, stops - p0, want_stop);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n, t0, bad;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk(!scl_low && !bit_tick && !start && !stop, "R8 reset outputs",
        int'({scl_low, bit_tick, start, stop}), 0);

    run_phases(0, 5, 3, 4, 0, "R2 low sel0", "R3 high sel0");
    run_phases(1, 2, 6, 4, 0, "R1 low sel1", "R1 high sel1");
    run_phases(3, 31, 31, 2, 0, "R2 low max", "R3 high max");
    run_phases(7, 1, 2, 2, 0, "R1 low sel7 clamp", "R1 high sel7 clamp");
    run_phases(0, 0, 0, 4, 0, "R4 low zero", "R4 high zero");
    run_phases(0, 4, 2, 4, 10, "R2 low with slave", "R5 stretched high");
    chk(ticks == rises, "R9 tick per pull-low", ticks, rises);

    // R8 idle: released, no ticks
    en = 1'b0; sel = 3'd0; lo = 5'd5; hi = 5'd3;
    t0 = ticks; bad = 0;
    repeat (60) begin
      @(negedge clk);
      if (scl_low) bad++;
    end
    chk(bad == 0 && ticks == t0, "R8 idle release", bad + ticks - t0, 0);

    // R8 first phase after enable is a released phase of H ticks
    en = 1'b1;
    n = 0;
    while (!scl_low && n < 50) begin
      @(negedge clk);
      n++;
    end
    chk(n == 3, "R8 first released phase", n, 3);
    en = 1'b0;
    repeat (40) @(negedge clk);

    // R6 / R7 valid conditions with SCL idle high
    sda_drv = 1'b0;
    cond_window(1, 0, "R6 start");
    sda_drv = 1'b1;
    cond_window(0, 1, "R7 stop");

    // SDA edges while SCL held low
    slave_hold = 1'b1;
    repeat (20) @(negedge clk);
    sda_drv = 1'b0;
    cond_window(0, 0, "R6 no start with SCL low");
    sda_drv = 1'b1;
    cond_window(0, 0, "R7 no stop with SCL low");

    // SCL rises on the same tick that SDA falls
    slave_hold = 1'b0;
    sda_drv = 1'b0;
    cond_window(0, 0, "R6 no start without setup");
    repeat (20) @(negedge clk);
    sda_drv = 1'b1;
    cond_window(0, 1, "R7 stop after setup");
    slave_hold = 1'b1;
    sda_drv = 1'b0;
    repeat (20) @(negedge clk);
    slave_hold = 1'b0;
    sda_drv = 1'b1;
    cond_window(0, 0, "R7 no stop without setup");
    repeat (20) @(negedge clk);

    // R10 one-tick SDA glitch
    sda_drv = 1'b0;
    @(negedge clk);
    sda_drv = 1'b1;
    cond_window(0, 0, "R10 glitch sel0");
    sel = 3'd1;
    repeat (20) @(negedge clk);
    sda_drv = 1'b0;
    @(negedge clk);
    sda_drv = 1'b1;
    cond_window(0, 0, "R10 glitch sel1");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule